// File: doc/BRIEF.md
# Tuner Synthesizer Control Slave

This block is a two-wire serial bus slave that loads the settings of a frequency synthesizer. It takes SCL and SDA as inputs that it oversamples on the system clock. It pulls SDA low through an open-drain enable. A 2-bit strap input selects one of four bus addresses, so up to four synthesizers can share one bus. Following a matching write address, each data byte is classified by its most significant bit. A 0 marks the upper part of the 15-bit divider word. A 1 marks a control byte. The divider word, the control byte and the band-output byte appear on parallel outputs.

The two divider bytes commit together, so the synthesizer never sees half a new ratio. The control byte and the band byte each commit on their own. Any number of data bytes may follow one address before STOP, which allows a frequency sweep. A read address returns one status byte, taken from a parallel input.

The sequencer has eight named states. IDLE waits for START. ADDR shifts in the address byte. ACK_SETUP waits for SCL to fall before it pulls SDA. ACK_SLOT holds the acknowledge and, on the next fall, enters WR_DATA, or enters RD_DATA after loading the status byte. RD_DATA drives the status bits. RD_ACK samples the master's reply. IGNORE waits out a transfer that is not addressed to this slave or has ended with a NACK. The transitions are as follows. START from any state leads to ADDR. STOP from any state leads to IDLE. ADDR goes to ACK_SETUP on a match, or to IGNORE otherwise. WR_DATA goes to ACK_SETUP after eight bits. ACK_SETUP goes to ACK_SLOT. RD_DATA goes to RD_ACK after eight bits. RD_ACK goes to ACK_SLOT on an ACK, or to IGNORE on a NACK.

Top module: `tuner_i2c_regs`

## Requirements
- R1: The slave answers the address byte {5'b11000, hw_addr_sel, dir}, MSB first. It pulls SDA low in the ninth clock of a matching address. dir=0 selects write and dir=1 selects read.
- R2: After an address that does not match, the slave does not acknowledge. Until the next START it drives nothing and changes no register.
- R3: A data byte with bit 7 = 0 supplies bits 6:0 as divider[14:8]. The next byte supplies divider[7:0]. freq_div_o changes only once the second byte has arrived.
- R4: A data byte with bit 7 = 1 is stored whole on ctrl_o. The byte after it is stored whole on band_o.
- R5: After a completed pair or a completed control/band couple, the next byte is classified again by bit 7. Successive pairs within one transfer each update freq_div_o.
- R6: The slave acknowledges every write data byte that follows a matching address.
- R7: A STOP in the middle of a pair discards the first byte. All values committed earlier are kept.
- R8: A repeated START clears the byte sequencing, so the first data byte after it is classified by bit 7.
- R9: In a read, status_i is shifted out MSB first after the address acknowledge. After a NACK from the master, SDA stays released until the next START.
- R10: After reset, all register outputs are zero and SDA is released.
- R11: A STOP returns the slave to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire |
| hw_addr_sel | input | 2 | Strap that selects the low address bits |
| status_i | input | 8 | Byte returned by a read |
| sda_pull_o | output | 1 | 1 pulls SDA low (open drain) |
| freq_div_o | output | 15 | Committed divider ratio |
| ctrl_o | output | 8 | Committed control byte |
| band_o | output | 8 | Committed band-output byte |

## Verification
The hardest case to reach from the ports is a frequency pair cut in half: a first byte is pending and the transfer ends before its partner arrives. If the pending state leaked, the damage would appear only later, on some unrelated byte. The stimulus therefore ends a write with STOP right after one upper byte. It also sends a repeated START after an upper byte and follows it with a byte that would otherwise be taken as the lower half. The expected divider shows whether the pending half was dropped.

// File: rtl/tuner_i2c_pkg.sv
package tuner_i2c_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_ACK_SETUP,
        S_ACK_SLOT,
        S_WR_DATA,
        S_RD_DATA,
        S_RD_ACK,
        S_IGNORE
    } bus_state_e;

    typedef enum logic [1:0] {
        ROLE_ANY,
        ROLE_FREQ_LO,
        ROLE_BAND
    } byte_role_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int PIPE_W = SYNC_STAGES + 1;

    logic [PIPE_W-1:0] scl_pipe;
    logic [PIPE_W-1:0] sda_pipe;
    logic scl_now, scl_prev, sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[PIPE_W-2:0], scl_i};
            sda_pipe <= {sda_pipe[PIPE_W-2:0], sda_i};
        end
    end

    assign scl_now   = scl_pipe[SYNC_STAGES-1];
    assign scl_prev  = scl_pipe[SYNC_STAGES];
    assign sda_s     = sda_pipe[SYNC_STAGES-1];
    assign sda_prev  = sda_pipe[SYNC_STAGES];
    assign scl_rise  = scl_now & ~scl_prev;
    assign scl_fall  = ~scl_now & scl_prev;
    assign start_det = scl_now & scl_prev & sda_prev & ~sda_s;
    assign stop_det  = scl_now & scl_prev & ~sda_prev & sda_s;

    // START and STOP both need SDA to move, so they cannot coincide
    a_r11_start_stop_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_det && stop_det));
endmodule

// File: rtl/tuner_reg_bank.sv
module tuner_reg_bank
    import tuner_i2c_pkg::*;
#(
    parameter int FREQ_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seq_clr,
    input  logic              byte_stb,
    input  logic [BYTE_W-1:0] byte_val,
    output logic [FREQ_W-1:0] freq_q,
    output logic [BYTE_W-1:0] ctrl_q,
    output logic [BYTE_W-1:0] band_q
);
    localparam int HI_W = FREQ_W - BYTE_W;

    byte_role_e      role;
    logic [HI_W-1:0] hi_pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            role    <= ROLE_ANY;
            hi_pend <= '0;
            freq_q  <= '0;
            ctrl_q  <= '0;
            band_q  <= '0;
        end else if (seq_clr) begin
            role <= ROLE_ANY;
        end else if (byte_stb) begin
            unique case (role)
                ROLE_FREQ_LO: begin
                    freq_q <= {hi_pend, byte_val};
                    role   <= ROLE_ANY;
                end
                ROLE_BAND: begin
                    band_q <= byte_val;
                    role   <= ROLE_ANY;
                end
                default: begin
                    if (byte_val[BYTE_W-1]) begin
                        ctrl_q <= byte_val;
                        role   <= ROLE_BAND;
                    end else begin
                        hi_pend <= byte_val[HI_W-1:0];
                        role    <= ROLE_FREQ_LO;
                    end
                end
            endcase
        end
    end

    a_r3_freq_only_on_pair: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(freq_q) |-> $past(byte_stb && role == ROLE_FREQ_LO));
    a_r4_band_after_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(band_q) |-> $past(byte_stb && role == ROLE_BAND));
    a_r8_start_clears_role: assert property (@(posedge clk) disable iff (!rst_n)
        seq_clr |=> role == ROLE_ANY);
endmodule

// File: rtl/tuner_i2c_regs.sv
module tuner_i2c_regs
    import tuner_i2c_pkg::*;
#(
    parameter int          SEL_W       = 2,
    parameter logic [4:0]  ADDR_HI     = 5'b11000,
    parameter int          FREQ_W      = 15,
    parameter int          SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [SEL_W-1:0]  hw_addr_sel,
    input  logic [BYTE_W-1:0] status_i,
    output logic              sda_pull_o,
    output logic [FREQ_W-1:0] freq_div_o,
    output logic [BYTE_W-1:0] ctrl_o,
    output logic [BYTE_W-1:0] band_o
);
    localparam int                CNT_W    = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(BYTE_W - 1);

    logic sda_s, scl_rise, scl_fall, start_det, stop_det;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    bus_state_e        state, state_nx;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] rx_byte;
    logic              is_read;
    logic              pull_q;
    logic              last_rise, addr_match, wr_byte_stb;

    assign rx_byte     = {shreg[BYTE_W-2:0], sda_s};
    assign last_rise   = scl_rise && (bit_cnt == LAST_BIT);
    assign addr_match  = (rx_byte[BYTE_W-1:1] == {ADDR_HI, hw_addr_sel});
    assign wr_byte_stb = (state == S_WR_DATA) && last_rise;

    // next state
    always_comb begin
        state_nx = state;
        if (start_det) begin
            state_nx = S_ADDR;
        end else if (stop_det) begin
            state_nx = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE, S_IGNORE: state_nx = state;
                S_ADDR:      if (last_rise) state_nx = addr_match ? S_ACK_SETUP : S_IGNORE;
                S_WR_DATA:   if (last_rise) state_nx = S_ACK_SETUP;
                S_ACK_SETUP: if (scl_fall)  state_nx = S_ACK_SLOT;
                S_ACK_SLOT:  if (scl_fall)  state_nx = is_read ? S_RD_DATA : S_WR_DATA;
                S_RD_DATA:   if (scl_fall && bit_cnt == LAST_BIT) state_nx = S_RD_ACK;
                S_RD_ACK:    if (scl_rise)  state_nx = sda_s ? S_IGNORE : S_ACK_SLOT;
                default:     state_nx = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            is_read <= 1'b0;
            pull_q  <= 1'b0;
        end else if (start_det) begin
            bit_cnt <= '0;
            pull_q  <= 1'b0;
        end else if (stop_det) begin
            pull_q  <= 1'b0;
        end else begin
            unique case (state)
                S_ADDR, S_WR_DATA: begin
                    if (scl_rise) begin
                        shreg   <= rx_byte;
                        bit_cnt <= bit_cnt + 1'b1;
                        if (state == S_ADDR && bit_cnt == LAST_BIT) is_read <= sda_s;
                    end
                end
                S_ACK_SETUP: if (scl_fall) pull_q <= 1'b1;
                S_ACK_SLOT: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (is_read) begin
                            shreg  <= status_i;
                            pull_q <= ~status_i[BYTE_W-1];
                        end else begin
                            pull_q <= 1'b0;
                        end
                    end
                end
                S_RD_DATA: begin
                    if (scl_fall) begin
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == LAST_BIT) begin
                            pull_q <= 1'b0;
                        end else begin
                            shreg  <= shreg << 1;
                            pull_q <= ~shreg[BYTE_W-2];
                        end
                    end
                end
                default: pull_q <= 1'b0;
            endcase
        end
    end

    assign sda_pull_o = pull_q;

    tuner_reg_bank #(.FREQ_W(FREQ_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .seq_clr  (start_det),
        .byte_stb (wr_byte_stb),
        .byte_val (rx_byte),
        .freq_q   (freq_div_o),
        .ctrl_q   (ctrl_o),
        .band_q   (band_o)
    );

    a_r11_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == S_IDLE) && !sda_pull_o);
    a_r8_start_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> state == S_ADDR);
    a_r2_ignore_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IGNORE || state == S_IDLE) |-> !sda_pull_o);
    a_r9_master_ack_slot_free: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_RD_ACK |-> !sda_pull_o);
    a_r6_ack_held_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ACK_SLOT && $past(state) == S_ACK_SETUP) |-> sda_pull_o);
endmodule

// File: tb/test_tuner_i2c_regs.sv
module test_tuner_i2c_regs;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 20;
    localparam int WATCHDOG   = 150000;

    typedef struct {
        string       req;
        logic [15:0] val;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [1:0]  hw_sel = 2'b10;
    logic [7:0]  status = 8'h00;
    logic        sda_pull;
    logic [14:0] freq;
    logic [7:0]  ctrl, band;
    wire         sda_bus = sda_m & ~sda_pull;

    int   n_vec = 0;
    int   n_bad = 0;
    bit   done = 0;
    exp_t exp_q[$];
    logic [15:0] obs_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    tuner_i2c_regs i_tuner_i2c_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_bus),
        .hw_addr_sel (hw_sel),
        .status_i    (status),
        .sda_pull_o  (sda_pull),
        .freq_div_o  (freq),
        .ctrl_o      (ctrl),
        .band_o      (band)
    );

    task automatic chk(input string req, input logic [15:0] expv, input logic [15:0] act);
        exp_q.push_back('{req, expv});
        obs_q.push_back(act);
    endtask

    task automatic gap(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; gap(HALF);
        scl_m = 1'b1; gap(HALF);
        sda_m = 1'b0; gap(HALF);
        scl_m = 1'b0; gap(HALF);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; gap(HALF);
        scl_m = 1'b1; gap(HALF);
        sda_m = 1'b1; gap(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; gap(HALF);
            scl_m = 1'b1; gap(HALF);
            scl_m = 1'b0;
        end
        sda_m = 1'b1; gap(HALF);
        scl_m = 1'b1; gap(HALF/2);
        ack = sda_bus; gap(HALF/2);
        scl_m = 1'b0; gap(HALF);
    endtask

    task automatic read_byte(input logic nack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            gap(HALF);
            scl_m = 1'b1; gap(HALF/2);
            b[i] = sda_bus; gap(HALF/2);
            scl_m = 1'b0;
        end
        gap(4);
        sda_m = nack; gap(HALF);
        scl_m = 1'b1; gap(HALF);
        scl_m = 1'b0; gap(4);
        sda_m = 1'b1; gap(HALF);
    endtask

    // scoreboard monitor
    initial begin
        exp_t        e;
        logic [15:0] o;
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0 && obs_q.size() > 0) begin
                e = exp_q.pop_front();
                o = obs_q.pop_front();
                n_vec++;
                if (o !== e.val) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", e.req, o, e.val);
                end
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R11 watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic       a;
        logic [7:0] rb;
        gap(5);
        rst_n = 1'b1;
        gap(5);
        chk("R10 freq reset", 16'h0, {1'b0, freq});
        chk("R10 ctrl reset", 16'h0, {8'h0, ctrl});
        chk("R10 band reset", 16'h0, {8'h0, band});
        chk("R10 sda released", 16'h0, {15'h0, sda_pull});

        // plain pair
        bus_start();
        send_byte(8'hC4, a); chk("R1 address ack", 16'h0, {15'h0, a});
        send_byte(8'h12, a); chk("R6 hi byte ack", 16'h0, {15'h0, a});
        chk("R3 no change after hi", 16'h0, {1'b0, freq});
        send_byte(8'h34, a); chk("R6 lo byte ack", 16'h0, {15'h0, a});
        bus_stop();
        chk("R3 pair committed", 16'h1234, {1'b0, freq});
        chk("R11 released after stop", 16'h0, {15'h0, sda_pull});

        // control then band
        bus_start();
        send_byte(8'hC4, a);
        send_byte(8'h9A, a); chk("R6 ctrl ack", 16'h0, {15'h0, a});
        chk("R4 ctrl stored", 16'h9A, {8'h0, ctrl});
        send_byte(8'h5C, a);
        bus_stop();
        chk("R4 band stored", 16'h5C, {8'h0, band});
        chk("R4 freq untouched", 16'h1234, {1'b0, freq});

        // sweep and reclassification
        bus_start();
        send_byte(8'hC4, a);
        send_byte(8'h01, a); send_byte(8'h00, a);
        chk("R5 sweep step 1", 16'h0100, {1'b0, freq});
        send_byte(8'h02, a); send_byte(8'h80, a);
        chk("R5 sweep step 2", 16'h0280, {1'b0, freq});
        send_byte(8'h85, a); send_byte(8'h07, a);
        chk("R5 ctrl after pair", 16'h85, {8'h0, ctrl});
        chk("R5 band after ctrl", 16'h07, {8'h0, band});
        bus_stop();

        // aborted pair
        bus_start();
        send_byte(8'hC4, a);
        send_byte(8'h7F, a);
        bus_stop();
        chk("R7 half pair dropped", 16'h0280, {1'b0, freq});
        chk("R7 ctrl kept", 16'h85, {8'h0, ctrl});
        bus_start();
        send_byte(8'hC4, a);
        send_byte(8'h66, a);
        chk("R7 stale hi not used", 16'h0280, {1'b0, freq});
        send_byte(8'h01, a);
        bus_stop();
        chk("R7 fresh pair", 16'h6601, {1'b0, freq});

        // repeated start mid pair
        bus_start();
        send_byte(8'hC4, a);
        send_byte(8'h11, a);
        bus_start();
        send_byte(8'hC4, a); chk("R8 address after Sr", 16'h0, {15'h0, a});
        send_byte(8'h22, a);
        chk("R8 byte after Sr is hi", 16'h6601, {1'b0, freq});
        send_byte(8'h33, a);
        bus_stop();
        chk("R8 pair after Sr", 16'h2233, {1'b0, freq});

        // non-matching address
        bus_start();
        send_byte(8'hC0, a); chk("R2 no ack on mismatch", 16'h1, {15'h0, a});
        send_byte(8'h05, a); chk("R2 data not acked", 16'h1, {15'h0, a});
        send_byte(8'h06, a);
        chk("R2 freq unchanged", 16'h2233, {1'b0, freq});
        send_byte(8'hF0, a);
        chk("R2 ctrl unchanged", 16'h85, {8'h0, ctrl});
        bus_stop();

        // other strap value
        hw_sel = 2'b01;
        bus_start();
        send_byte(8'hC4, a); chk("R1 old address refused", 16'h1, {15'h0, a});
        bus_stop();
        bus_start();
        send_byte(8'hC2, a); chk("R1 strap address ack", 16'h0, {15'h0, a});
        send_byte(8'hB1, a);
        bus_stop();
        chk("R1 write via strap", 16'hB1, {8'h0, ctrl});

        // read
        status = 8'hA5;
        bus_start();
        send_byte(8'hC3, a); chk("R9 read address ack", 16'h0, {15'h0, a});
        read_byte(1'b1, rb);
        chk("R9 status byte", 16'hA5, {8'h0, rb});
        chk("R9 released after nack", 16'h0, {15'h0, sda_pull});
        gap(HALF);
        chk("R9 still released", 16'h0, {15'h0, sda_pull});
        bus_stop();
        status = 8'h3C;
        bus_start();
        send_byte(8'hC3, a);
        read_byte(1'b0, rb);
        chk("R9 second status", 16'h3C, {8'h0, rb});
        read_byte(1'b1, rb);
        chk("R9 repeat after ack", 16'h3C, {8'h0, rb});
        bus_stop();
        chk("R11 idle after read", 16'h0, {15'h0, sda_pull});

        gap(10);
        if (exp_q.size() != 0 || obs_q.size() != 0) begin
            n_bad++;
            $display("FAIL R11 scoreboard: actual %0d left expected 0", exp_q.size());
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule